// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block turns the raw digital outputs of two analog comparators into interrupt flags and one gated interrupt request. It synchronizes each asynchronous comparator bit and can invert it for each channel. It then watches the resulting value for the kind of transition chosen in that channel's event-select field. When a qualifying transition is seen, a sticky flag for that channel is set.

Software reaches the block through a small synchronous register port. A write strobe, an address and write data update the registers. Read data follows the address in the same cycle. Software can read the current post-inversion output of both channels. It can also read the flags and write them: a 0 clears a flag and a 1 forces it.

The request to the processor is raised only when three enables are all set: a channel enable, a peripheral enable and a global enable. The flags themselves latch whatever the enables are.

Register map (8-bit data, 3-bit address):
- Addresses 0 and 1 are the channel 0 and channel 1 control registers. Bit 0 is polarity (1 = invert). Bits [2:1] are event select: 00 none, 01 rising, 10 falling, 11 any change. Bit 3 is the channel enable.
- Address 2 holds the flags in bits [1:0], one bit per channel.
- Address 3 holds the peripheral enable in bit 0 and the global enable in bit 1.
- Address 4 is the read-only status: the post-inversion outputs in bits [1:0].

Unused bits read as 0.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: With event select 00 a channel never sets its flag, whatever its input does.
- R2: With event select 01 a flag is set when the post-inversion value goes from 0 to 1, and not on a fall. With 10 it is set on a fall and not on a rise.
- R3: With event select 11 a flag is set on every change of the post-inversion value, in either direction.
- R4: The polarity bit inverts the synchronized input before edge detection. Address 4 bits [1:0] report the post-inversion value of each channel.
- R5: A flag that is set stays set until software writes 0 to its bit at address 2.
- R6: Writing 1 to a flag bit at address 2 sets that flag. If the enables are set, this raises irq exactly as a hardware event would.
- R7: irq is 1 only when the peripheral enable and the global enable are both 1 and at least one channel has both its flag and its channel enable at 1.
- R8: A qualifying event sets the flag even when the channel, peripheral or global enable is 0.
- R9: A hardware event in the same cycle as a software write of 0 to that flag leaves the flag set.
- R10: A write to a channel's control register that changes its polarity does not by itself create an event.
- R11: After reset all registers read 0 and irq is 0. A raw input change seen within three clock edges is reflected in the flag after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator outputs, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for the addressed register |
| irq | output | 1 | Gated interrupt request |

## Verification
The checker requires that a channel's raw input does not change in the cycle that completes a write to that channel's control register. Under that condition, the reload of the previous-value register is the only source of a changed sample, so the rule "no event in the cycle after a control write" can hold. The bench keeps the inputs steady for several cycles around every control write. It changes them only at falling clock edges, well apart from register writes. The one exception is the same-cycle race, where a timed input change is aimed at a flag write rather than a control write.

// File: rtl/cmp_irq_pkg.sv
// Shared constants for the comparator interrupt controller.
// Assumes an 8-bit register port with a 3-bit address and two channels.
package cmp_irq_pkg;
    localparam int CH_N   = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    // Event-select encodings
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_RISE = 2'b01,
        EV_FALL = 2'b10,
        EV_ANY  = 2'b11
    } ev_sel_t;

    // Register addresses (channel control registers sit at 0 .. CH_N-1)
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;

    // Control register field positions
    localparam int CTRL_POL_BIT = 0;
    localparam int CTRL_SEL_LO  = 1;
    localparam int CTRL_EN_BIT  = 3;

    // Enable register field positions
    localparam int EN_PERIPH_BIT = 0;
    localparam int EN_GLOBAL_BIT = 1;
endpackage

// File: rtl/cmp_sync.sv
// Multi-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that is stable far longer than STAGES cycles.
module cmp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // First stage samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_chan.sv
// One channel: polarity inversion, previous-value register and edge select.
// Assumes raw_sync is already synchronous. cfg_load marks a control write,
// which reloads the previous value with the new post-inversion value.
module cmp_edge_chan
    import cmp_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    raw_sync,
    input  logic    pol,
    input  ev_sel_t sel,
    input  logic    cfg_load,
    input  logic    new_pol,
    output logic    post,
    output logic    evt
);
    logic prev_q;
    logic hit;

    // Apply the channel polarity
    always_comb post = raw_sync ^ pol;

    // Remember last value, reloaded on reconfiguration to avoid false edges
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (cfg_load) prev_q <= raw_sync ^ new_pol;
        else               prev_q <= post;
    end

    // Pick the transition kind chosen by the select field
    always_comb begin
        unique case (sel)
            EV_RISE: hit = post & ~prev_q;
            EV_FALL: hit = ~post & prev_q;
            EV_ANY:  hit = post ^ prev_q;
            default: hit = 1'b0;
        endcase
        evt = hit & ~cfg_load;
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
// Top: two comparator channels, sticky flags, register port and gated irq.
// Assumes single-cycle register writes. Read data is combinational on addr.
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   cmp_raw,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [CH_N-1:0] raw_sync;
    logic [CH_N-1:0] pol_q;
    ev_sel_t [CH_N-1:0] sel_q;
    logic [CH_N-1:0] chen_q;
    logic [CH_N-1:0] flag_q;
    logic [CH_N-1:0] post;
    logic [CH_N-1:0] evt;
    logic [CH_N-1:0] cfg_load;
    logic            peie_q;
    logic            gie_q;
    logic            wr_flags;
    logic            wr_enable;
    logic            unused_wdata;

    assign unused_wdata = ^wr_data[DATA_W-1:4];

    cmp_sync #(.W(CH_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (raw_sync)
    );

    genvar i;
    generate
        for (i = 0; i < CH_N; i++) begin : g_ch
            assign cfg_load[i] = wr_en && (addr == ADDR_W'(i));

            // Per-channel control register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pol_q[i]  <= 1'b0;
                    sel_q[i]  <= EV_NONE;
                    chen_q[i] <= 1'b0;
                end else if (cfg_load[i]) begin
                    pol_q[i]  <= wr_data[CTRL_POL_BIT];
                    sel_q[i]  <= ev_sel_t'(wr_data[CTRL_SEL_LO +: 2]);
                    chen_q[i] <= wr_data[CTRL_EN_BIT];
                end
            end

            cmp_edge_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_sync (raw_sync[i]),
                .pol      (pol_q[i]),
                .sel      (sel_q[i]),
                .cfg_load (cfg_load[i]),
                .new_pol  (wr_data[CTRL_POL_BIT]),
                .post     (post[i]),
                .evt      (evt[i])
            );
        end
    endgenerate

    assign wr_flags  = wr_en && (addr == ADDR_FLAGS);
    assign wr_enable = wr_en && (addr == ADDR_ENABLE);

    // Sticky flags: software write applies first, hardware events win
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (wr_flags ? wr_data[CH_N-1:0] : flag_q) | evt;
    end

    // Peripheral and global enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peie_q <= 1'b0;
            gie_q  <= 1'b0;
        end else if (wr_enable) begin
            peie_q <= wr_data[EN_PERIPH_BIT];
            gie_q  <= wr_data[EN_GLOBAL_BIT];
        end
    end

    // Request gating through all three enables
    always_comb irq = peie_q & gie_q & (|(flag_q & chen_q));

    // Read mux
    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_FLAGS:  rd_data[CH_N-1:0] = flag_q;
            ADDR_ENABLE: begin
                rd_data[EN_PERIPH_BIT] = peie_q;
                rd_data[EN_GLOBAL_BIT] = gie_q;
            end
            ADDR_STATUS: rd_data[CH_N-1:0] = post;
            default: begin
                for (int c = 0; c < CH_N; c++) begin
                    if (addr == ADDR_W'(c)) begin
                        rd_data[CTRL_POL_BIT]     = pol_q[c];
                        rd_data[CTRL_SEL_LO +: 2] = sel_q[c];
                        rd_data[CTRL_EN_BIT]      = chen_q[c];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/cmp_irq_chk.sv
// Checker for cmp_irq_ctrl, attached by bind. Assumes raw inputs are steady
// in the cycle that completes a control-register write.
module cmp_irq_chk
    import cmp_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CH_N-1:0]   flag,
    input logic [CH_N-1:0]   evt,
    input logic [CH_N-1:0]   cfg_load,
    input logic [2*CH_N-1:0] sel,
    input logic              peie,
    input logic              gie,
    input logic              irq
);
    genvar i;
    generate
        for (i = 0; i < CH_N; i++) begin : g_chk
            assert_none_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (sel[2*i +: 2] == EV_NONE) |-> !evt[i]);
            assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !(wr_en && addr == ADDR_FLAGS)) |=> flag[i]);
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flag[i]);
            assert_no_reload_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_load[i] |=> !evt[i]);
        end
    endgenerate

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (peie && gie && (flag != '0)));
endmodule

bind cmp_irq_ctrl cmp_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .flag     (flag_q),
    .evt      (evt),
    .cfg_load (cfg_load),
    .sel      (sel_q),
    .peie     (peie_q),
    .gie      (gie_q),
    .irq      (irq)
);

// File: tb/sim_cmp_irq_ctrl.sv
// Directed bench for cmp_irq_ctrl: one task per scenario, each self-checking.
module sim_cmp_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    cmp_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [7:0] ctrl(input logic en, input logic [1:0] sel, input logic pol);
        return {4'b0, en, sel, pol};
    endfunction

    task automatic clear_all();
        wr(3'd2, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R11 reset reg", d, 8'h00);
        end
        chk("R11 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_none();
        logic [7:0] d;
        cmp_raw = 2'b11; settle();
        cmp_raw = 2'b00; settle();
        rd(3'd2, d);
        chk("R1 select none", d, 8'h00);
    endtask

    task automatic t_rise_fall();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b0, 2'b01, 1'b0));
        wr(3'd1, ctrl(1'b0, 2'b10, 1'b0));
        cmp_raw = 2'b11; settle();
        rd(3'd2, d);
        chk("R2 rise sets ch0 only", d, 8'h01);
        clear_all();
        cmp_raw = 2'b00; settle();
        rd(3'd2, d);
        chk("R2 fall sets ch1 only", d, 8'h02);
        clear_all();
    endtask

    task automatic t_any();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b0, 2'b11, 1'b0));
        cmp_raw[0] = 1'b1; settle();
        rd(3'd2, d);
        chk("R3 any on rise", d & 8'h01, 8'h01);
        clear_all();
        cmp_raw[0] = 1'b0; settle();
        rd(3'd2, d);
        chk("R3 any on fall", d & 8'h01, 8'h01);
        clear_all();
    endtask

    task automatic t_polarity();
        logic [7:0] d;
        wr(3'd1, ctrl(1'b0, 2'b01, 1'b1));
        settle();
        rd(3'd4, d);
        chk("R4 status inverted", d, 8'h02);
        clear_all();
        cmp_raw[1] = 1'b1; settle();
        rd(3'd2, d);
        chk("R4 inverted rise no flag", d, 8'h00);
        cmp_raw[1] = 1'b0; settle();
        rd(3'd2, d);
        chk("R4 raw fall sets flag", d, 8'h02);
        clear_all();
        wr(3'd1, ctrl(1'b0, 2'b00, 1'b0));
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b0, 2'b01, 1'b0));
        cmp_raw[0] = 1'b1; settle();
        cmp_raw[0] = 1'b0; settle();
        rd(3'd2, d);
        chk("R5 flag held", d, 8'h01);
        wr(3'd2, 8'h00);
        rd(3'd2, d);
        chk("R5 flag cleared", d, 8'h00);
    endtask

    task automatic t_soft_set_gate();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b1, 2'b00, 1'b0));
        wr(3'd3, 8'h03);
        wr(3'd2, 8'h01);
        rd(3'd2, d);
        chk("R6 soft set flag", d, 8'h01);
        chk("R6 soft set irq", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h01);
        #1 chk("R7 global off blocks", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h02);
        #1 chk("R7 periph off blocks", {7'b0, irq}, 8'h00);
        wr(3'd3, 8'h03);
        wr(3'd0, ctrl(1'b0, 2'b00, 1'b0));
        #1 chk("R7 channel off blocks", {7'b0, irq}, 8'h00);
        wr(3'd2, 8'h02);
        #1 chk("R7 other flag not enabled", {7'b0, irq}, 8'h00);
        wr(3'd1, ctrl(1'b1, 2'b00, 1'b0));
        #1 chk("R7 ch1 enabled", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h00);
        clear_all();
    endtask

    task automatic t_enables_off();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b0, 2'b01, 1'b0));
        cmp_raw[0] = 1'b1; settle();
        rd(3'd2, d);
        chk("R8 flag with enables off", d, 8'h01);
        chk("R8 irq stays low", {7'b0, irq}, 8'h00);
        cmp_raw[0] = 1'b0; settle();
        clear_all();
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        wr(3'd0, ctrl(1'b0, 2'b11, 1'b0));
        settle();
        wr(3'd2, 8'h01);
        @(negedge clk);
        cmp_raw[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd2, d);
        chk("R9 event beats clear", d, 8'h01);
        settle();
        clear_all();
    endtask

    task automatic t_reconfig();
        logic [7:0] d;
        settle();
        clear_all();
        wr(3'd0, ctrl(1'b0, 2'b11, 1'b1));
        settle();
        rd(3'd2, d);
        chk("R10 polarity change no event", d, 8'h00);
        rd(3'd4, d);
        chk("R4 status after polarity", d & 8'h01, 8'h00);
        wr(3'd0, 8'h00);
        cmp_raw = 2'b00; settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_none();
        t_rise_fall();
        t_any();
        t_polarity();
        t_sticky();
        t_soft_set_gate();
        t_enables_off();
        t_set_wins();
        t_reconfig();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule